// File: doc/BRIEF.md
# Packed Subword Arithmetic Unit

This unit is an execution stage for packed pixel arithmetic. Two 64-bit source words are each treated as four independent 16-bit lanes. One operation, chosen by a 4-bit opcode, is applied to every lane pair in the same cycle. Carries and borrows stay inside their own lane. The operations cover three overflow policies for add and subtract, fused shift-then-add forms for cheap scaling by powers of two, a rounded average, and three kinds of lane shift.

An operation is issued by raising `in_valid` for one cycle with the opcode, the shift amount and both operands. The 64-bit result appears in a register on the next clock edge, and `out_valid` is high for that one cycle. When no operation is issued, the result register keeps its value. There is no back-pressure: the unit can accept one operation on every cycle.

Top module: `lane_alu`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. After reset, `out_valid` is 0 and `result` is all zeros.
- R2: Each 16-bit lane (lane i is bits 16i+15 down to 16i) is computed from the matching lanes of `src_a` and `src_b` alone. No carry, borrow or shifted bit crosses a lane boundary.
- R3: Opcode 0 gives a+b and opcode 3 gives a-b, both modulo 2^16.
- R4: Opcode 1 (add) and opcode 4 (subtract) treat lanes as two's-complement values and clamp the exact result to the range 0x8000 to 0x7FFF.
- R5: Opcode 2 (add) and opcode 5 (subtract) treat lanes as unsigned values. A result above 0xFFFF gives 0xFFFF, and a result below zero gives 0x0000.
- R6: Opcode 6 gives signed a times 2^k plus signed b, clamped to the signed 16-bit range, where k = `shamt[1:0]` (0 to 3).
- R7: Opcode 7 gives signed a arithmetically shifted right by k, plus signed b, clamped to the signed 16-bit range, where k = `shamt[1:0]`.
- R8: Opcode 8 gives (a+b+1)/2 on unsigned lanes, truncated. It is computed without overflow.
- R9: Opcode 9 shifts a right by `shamt` (0 to 15) with sign fill, opcode 10 shifts it right with zero fill, and opcode 11 shifts it left with zero fill. `src_b` is not used by these opcodes.
- R10: Opcodes 12 to 15 produce an all-zero result.
- R11: While `in_valid` is low, `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Issues an operation in this cycle |
| op | input | 4 | Operation code (see requirements) |
| shamt | input | 4 | Shift amount; bits 1:0 give the scale for opcodes 6 and 7 |
| src_a | input | 64 | First packed operand |
| src_b | input | 64 | Second packed operand |
| out_valid | output | 1 | Result register was loaded at the last edge |
| result | output | 64 | Registered packed result |

## Verification
Some properties are checked by assertions on every issue cycle. These are the one-cycle valid timing, the held result, that unsigned-clamped adds never shrink and unsigned-clamped subtracts never grow, that signed-clamped adds of like-signed lanes keep their sign, that an average lies between its two inputs, and that left shifts leave zero low bits. Exact lane values are shown only by the bench, which compares every result with an arithmetic model. It does this for every opcode and every shift amount, over operand pairs drawn from 0x0000, 0x0001, 0x7FFF, 0x8000, 0xFFFF and other edge values, and then over random operands. The bench also checks that no carry crosses a lane, that the reset values are correct, and that unused opcodes give zero.

// File: rtl/lane_alu_pkg.sv
package lane_alu_pkg;
  parameter int unsigned LANE_W = 16;
  localparam int unsigned EXT_W = LANE_W + 4;
  localparam int unsigned SH_W  = $clog2(LANE_W);

  typedef enum logic [3:0] {
    OP_ADD_WRAP = 4'd0,
    OP_ADD_SSAT = 4'd1,
    OP_ADD_USAT = 4'd2,
    OP_SUB_WRAP = 4'd3,
    OP_SUB_SSAT = 4'd4,
    OP_SUB_USAT = 4'd5,
    OP_SCL_ADD  = 4'd6,
    OP_DIV_ADD  = 4'd7,
    OP_MEAN     = 4'd8,
    OP_SHR_SGN  = 4'd9,
    OP_SHR_ZRO  = 4'd10,
    OP_SHL      = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    CLAMP_NONE = 2'd0,
    CLAMP_SGN  = 2'd1,
    CLAMP_UNS  = 2'd2
  } clamp_e;

  function automatic logic signed [EXT_W-1:0] sext(input logic [LANE_W-1:0] v);
    return {{(EXT_W-LANE_W){v[LANE_W-1]}}, v};
  endfunction

  function automatic logic signed [EXT_W-1:0] zext(input logic [LANE_W-1:0] v);
    return {{(EXT_W-LANE_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/lane_alu_sat.sv
module lane_alu_sat
  import lane_alu_pkg::*;
(
  input  logic signed [EXT_W-1:0] pre,
  input  clamp_e                  mode,
  output logic [LANE_W-1:0]       res,
  output logic                    hit_hi,
  output logic                    hit_lo
);
  localparam logic signed [EXT_W-1:0] SMAX = EXT_W'((1 << (LANE_W-1)) - 1);
  localparam logic signed [EXT_W-1:0] SMIN = -SMAX - EXT_W'(1);
  localparam logic signed [EXT_W-1:0] UMAX = EXT_W'((1 << LANE_W) - 1);
  localparam logic signed [EXT_W-1:0] ZERO = '0;

  always_comb begin
    hit_hi = 1'b0;
    hit_lo = 1'b0;
    res    = pre[LANE_W-1:0];
    unique case (mode)
      CLAMP_SGN: begin
        hit_hi = pre > SMAX;
        hit_lo = pre < SMIN;
        if (hit_hi)      res = SMAX[LANE_W-1:0];
        else if (hit_lo) res = SMIN[LANE_W-1:0];
      end
      CLAMP_UNS: begin
        hit_hi = pre > UMAX;
        hit_lo = pre < ZERO;
        if (hit_hi)      res = UMAX[LANE_W-1:0];
        else if (hit_lo) res = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lane_alu_lane.sv
module lane_alu_lane
  import lane_alu_pkg::*;
(
  input  op_e               op,
  input  logic [SH_W-1:0]   sh,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  output logic [LANE_W-1:0] res,
  output logic              clamp_hi,
  output logic              clamp_lo
);
  logic signed [EXT_W-1:0] sa, sb, ua, ub, pre;
  logic [1:0]              k;
  clamp_e                  mode;

  assign sa = sext(a);
  assign sb = sext(b);
  assign ua = zext(a);
  assign ub = zext(b);
  assign k  = sh[1:0];

  always_comb begin
    pre  = '0;
    mode = CLAMP_NONE;
    case (op)
      OP_ADD_WRAP: pre = ua + ub;
      OP_ADD_SSAT: begin pre = sa + sb; mode = CLAMP_SGN; end
      OP_ADD_USAT: begin pre = ua + ub; mode = CLAMP_UNS; end
      OP_SUB_WRAP: pre = ua - ub;
      OP_SUB_SSAT: begin pre = sa - sb; mode = CLAMP_SGN; end
      OP_SUB_USAT: begin pre = ua - ub; mode = CLAMP_UNS; end
      OP_SCL_ADD:  begin pre = (sa <<< k) + sb; mode = CLAMP_SGN; end
      OP_DIV_ADD:  begin pre = (sa >>> k) + sb; mode = CLAMP_SGN; end
      OP_MEAN:     pre = (ua + ub + EXT_W'(1)) >>> 1;
      OP_SHR_SGN:  pre = sa >>> sh;
      OP_SHR_ZRO:  pre = ua >>> sh;
      OP_SHL:      pre = ua <<< sh;
      default:     pre = '0;
    endcase
  end

  lane_alu_sat u_sat (
    .pre    (pre),
    .mode   (mode),
    .res    (res),
    .hit_hi (clamp_hi),
    .hit_lo (clamp_lo)
  );
endmodule

// File: rtl/lane_alu.sv
module lane_alu
  import lane_alu_pkg::*;
#(
  parameter int unsigned LANES = 4,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [3:0]      op,
  input  logic [SH_W-1:0] shamt,
  input  logic [DW-1:0]   src_a,
  input  logic [DW-1:0]   src_b,
  output logic            out_valid,
  output logic [DW-1:0]   result
);
  op_e           op_q;
  logic [DW-1:0] comb_res;

  assign op_q = op_e'(op);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] a_l, b_l, r_l;
    logic              hi_l, lo_l;
    assign a_l = src_a[i*LANE_W +: LANE_W];
    assign b_l = src_b[i*LANE_W +: LANE_W];

    lane_alu_lane u_lane (
      .op       (op_q),
      .sh       (shamt),
      .a        (a_l),
      .b        (b_l),
      .res      (r_l),
      .clamp_hi (hi_l),
      .clamp_lo (lo_l)
    );
    assign comb_res[i*LANE_W +: LANE_W] = r_l;

    // R5: unsigned clamped add never falls below its first input
    a_r5_usat_add_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_q == OP_ADD_USAT) |-> (r_l >= a_l));
    // R5: unsigned clamped subtract never rises above its first input
    a_r5_usat_sub_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_q == OP_SUB_USAT) |-> (r_l <= a_l));
    // R5: an upper clamp on unsigned add yields the all-ones lane
    a_r5_usat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_q == OP_ADD_USAT && hi_l) |-> (r_l == '1));
    // R5: a lower clamp on unsigned subtract yields the zero lane
    a_r5_usat_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_q == OP_SUB_USAT && lo_l) |-> (r_l == '0));
    // R4: like-signed operands keep their sign under signed clamped add
    a_r4_ssat_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_q == OP_ADD_SSAT && a_l[LANE_W-1] == b_l[LANE_W-1])
      |-> (r_l[LANE_W-1] == a_l[LANE_W-1]));
    // R8: the mean lies between the two inputs
    a_r8_mean_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_q == OP_MEAN)
      |-> ((r_l >= a_l || r_l >= b_l) && (r_l <= a_l || r_l <= b_l)));
    // R9: a left shift leaves the vacated low bits at zero
    a_r9_shl_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_q == OP_SHL)
      |-> ((r_l & ~({LANE_W{1'b1}} << shamt)) == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= comb_res;
    end
  end

  // R1: a result follows each issue by one cycle
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R1: no result without an issue
  a_r1_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R11: the result holds while nothing is issued
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
endmodule

// File: tb/lane_alu_bench.sv
module lane_alu_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = '0;
  logic [3:0]  shamt = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic        out_valid;
  logic [63:0] result;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_alu u_lane_alu (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .shamt(shamt),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  function automatic int sclamp(int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int uclamp(int v);
    if (v > 65535) return 65535;
    if (v < 0) return 0;
    return v;
  endfunction

  function automatic logic [15:0] model(int o, int s, logic [15:0] a, logic [15:0] b);
    int sa, sb, ua, ub, r, k;
    sa = int'($signed(a)); sb = int'($signed(b));
    ua = int'(a); ub = int'(b); k = s % 4;
    case (o)
      0: r = ua + ub;
      1: r = sclamp(sa + sb);
      2: r = uclamp(ua + ub);
      3: r = ua - ub;
      4: r = sclamp(sa - sb);
      5: r = uclamp(ua - ub);
      6: r = sclamp(sa * (1 << k) + sb);
      7: r = sclamp((sa >>> k) + sb);
      8: r = (ua + ub + 1) / 2;
      9: r = sa >>> s;
      10: r = ua >> s;
      11: r = ua * (1 << s);
      default: r = 0;
    endcase
    return r[15:0];
  endfunction

  function automatic string tag(int o);
    case (o)
      0, 3: return "R3";
      1, 4: return "R4";
      2, 5: return "R5";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9, 10, 11: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic issue(int o, int s, logic [63:0] a, logic [63:0] b);
    logic [63:0] exp;
    for (int l = 0; l < 4; l++) exp[l*16 +: 16] = model(o, s, a[l*16 +: 16], b[l*16 +: 16]);
    @(negedge clk);
    op = 4'(o); shamt = 4'(s); src_a = a; src_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag(o), result, exp);
    if (!out_valid) begin
      total++; bad++;
      $display("FAIL R1 out_valid got=0 exp=1");
    end
  endtask

  logic [15:0] edges [8] = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000,
                             16'hFFFF, 16'h7FFE, 16'h8001, 16'h4000};

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset result", result, 64'h0);
    check("R1 reset valid", {63'h0, out_valid}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: a full lane 0 carry must not reach lane 1
    issue(0, 0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001);
    check("R2 no carry", result, 64'h0);
    // R2: a lane 1 borrow must not reach lane 2
    issue(3, 0, 64'h0000_0000_0000_0000, 64'h0000_0000_0001_0000);
    check("R2 no borrow", result, 64'h0000_0000_FFFF_0000);

    // R11: held value after issue with changing idle inputs
    issue(0, 0, 64'h0001_0002_0003_0004, 64'h0010_0020_0030_0040);
    src_a = '1; src_b = '1; op = 4'd2;
    repeat (3) @(negedge clk);
    check("R11 hold", result, 64'h0011_0022_0033_0044);
    check("R1 idle valid", {63'h0, out_valid}, 64'h0);

    // edge sweep: every opcode, every shift, every pairing of edge values
    for (int o = 0; o < 16; o++)
      for (int s = 0; s < 16; s++)
        for (int p = 0; p < 16; p++) begin
          logic [63:0] a, b;
          for (int l = 0; l < 4; l++) begin
            a[l*16 +: 16] = edges[(p + l) % 8];
            b[l*16 +: 16] = edges[(p / 2 + 3 * l) % 8];
          end
          issue(o, s, a, b);
        end

    // random operands for each opcode
    for (int o = 0; o < 16; o++)
      for (int n = 0; n < 200; n++)
        issue(o, $urandom_range(15), {$urandom, $urandom}, {$urandom, $urandom});

    // R10: unused opcode yields zero even with full operands
    issue(13, 5, '1, '1);
    check("R10 zero", result, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule